// File: doc/BRIEF.md
# JESD204B Lane Startup Sequencer

This block drives the link-layer startup of a single transmit lane in a four-lane converter link. The link carries four converters with one sample per converter in each frame and two octets per frame, so each lane carries one converter's 16-bit sample per frame. The block produces one octet per clock, a flag that marks control characters, and a phase indication. The 8b/10b encoder, scrambler and serializer sit downstream. Frame-aligned converter octets and the fourteen link configuration octets arrive on parallel inputs.

The lane starts in code group synchronisation and sends the comma character while the receiver holds its active-low synchronisation request low. After the request is released, the lane waits for the local multiframe boundary strobe. It then sends a fixed four-multiframe lane alignment sequence and moves straight on to converter data. A multiframe is sixteen frames of two octets, which is 32 octets. The request input is asynchronous and passes through a two-flop synchroniser. A new request at any point returns the lane to comma transmission.

Top module: `lane_start_seq`

## Requirements
- R1: While rst_n is low, and directly after it, tx_octet is 0xBC (K28.5), tx_is_k is 1 and link_phase is 0. The phase encoding is 0 for comma transmission, 1 for the alignment sequence and 2 for data.
- R2: While the synchronised request is low, every octet is 0xBC with tx_is_k high and link_phase 0. Strobes on mf_strobe have no effect in that time.
- R3: sync_req_n passes through two flip-flops. If sync_req_n is first sampled low at clock edge e, octets from edge e+2 onward are 0xBC with link_phase 0, whatever the phase was before.
- R4: After sync_req_n is first sampled high at edge e, the alignment sequence starts on the octet produced at the first edge at or after e+2 where mf_strobe is high. Strobes before e+2 are ignored and the lane keeps sending 0xBC.
- R5: The alignment sequence is exactly 128 octets long: 4 multiframes of 16 frames × 2 octets. link_phase is 1 throughout.
- R6: Octet 0 of every alignment multiframe is 0x1C (K28.0) and octet 31 is 0x7C (K28.3), both with tx_is_k high.
- R7: In the second alignment multiframe, octet 1 is 0x9C (K28.4) with tx_is_k high. Octets 2 to 15 are configuration octets 0 to 13, where configuration octet n is cfg_in[8n+7:8n], with tx_is_k low.
- R8: All other alignment octets carry data_in as sampled at the same clock edge, with tx_is_k low.
- R9: The octet after the last alignment octet is data, and from then on each octet is data_in sampled at the edge that produces it, with tx_is_k low and link_phase 2.
- R10: tx_is_k is high only on 0xBC, 0x1C, 0x7C and 0x9C control octets, and it is low on every octet taken from data_in or cfg_in.
- R11: mf_strobe has no effect during the alignment sequence or during data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Octet clock |
| rst_n | input | 1 | Active-low reset |
| sync_req_n | input | 1 | Asynchronous active-low synchronisation request from the receiver |
| mf_strobe | input | 1 | Marks that the octet produced at this edge begins a local multiframe |
| data_in | input | 8 | Frame-aligned converter octet |
| cfg_in | input | 112 | Fourteen link configuration octets, octet n in bits 8n+7:8n |
| tx_octet | output | 8 | Octet to the encoder |
| tx_is_k | output | 1 | High when tx_octet is a control character |
| link_phase | output | 2 | 0 comma, 1 alignment, 2 data |

## Verification
The hardest situation to reach is a new synchronisation request that lands in the middle of the alignment sequence, while the lane is inside the configuration octets of the second multiframe. The request must cut the sequence short exactly two octets later. The stimulus first runs one complete alignment and data phase. It then raises the request again with a strobe on the first edge at which the synchronised request is visible, lets 42 alignment octets go out, and drops the request. The stimulus also places stray strobes inside alignment and data and in the two edges before the synchroniser settles, so the strobe-ignoring rules are tested at their edges.

// File: rtl/lane_seq_pkg.sv
package lane_seq_pkg;
    typedef enum logic [1:0] {
        PH_CGS  = 2'd0,
        PH_ILA  = 2'd1,
        PH_DATA = 2'd2
    } phase_e;

    // Control characters, in their unencoded octet values
    localparam logic [7:0] SYM_COMMA    = 8'hBC; // K28.5
    localparam logic [7:0] SYM_MF_START = 8'h1C; // K28.0
    localparam logic [7:0] SYM_MF_END   = 8'h7C; // K28.3
    localparam logic [7:0] SYM_CFG_MARK = 8'h9C; // K28.4
endpackage

// File: rtl/seq_bit_sync.sv
module seq_bit_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    // Resets to 0: the lane treats reset as a pending request
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], d};
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/ila_octet_map.sv
module ila_octet_map
    import lane_seq_pkg::*;
#(
    parameter int MF_OCTETS  = 32,
    parameter int ILA_MF     = 4,
    parameter int CFG_OCTETS = 14,
    parameter int IDX_W      = 7
) (
    input  logic [IDX_W-1:0]        idx,
    input  logic [CFG_OCTETS*8-1:0] cfg_in,
    input  logic [7:0]              data_in,
    output logic [7:0]              octet,
    output logic                    is_k
);
    localparam int POS_W = $clog2(MF_OCTETS);
    localparam int MF_W  = IDX_W - POS_W;
    localparam int CFG_W = $clog2(CFG_OCTETS);

    logic [POS_W-1:0] pos;
    logic [MF_W-1:0]  mf;
    logic [7:0]       cfg_arr [CFG_OCTETS];

    assign pos = idx[POS_W-1:0];
    assign mf  = idx[IDX_W-1:POS_W];

    for (genvar g = 0; g < CFG_OCTETS; g++) begin : g_cfg
        assign cfg_arr[g] = cfg_in[g*8 +: 8];
    end

    always_comb begin
        octet = data_in;
        is_k  = 1'b0;
        if (pos == '0) begin
            octet = SYM_MF_START;
            is_k  = 1'b1;
        end else if (pos == POS_W'(MF_OCTETS - 1)) begin
            octet = SYM_MF_END;
            is_k  = 1'b1;
        end else if (mf == MF_W'(1) && pos == POS_W'(1)) begin
            octet = SYM_CFG_MARK;
            is_k  = 1'b1;
        end else if (mf == MF_W'(1) && pos >= POS_W'(2) && pos < POS_W'(2 + CFG_OCTETS)) begin
            octet = cfg_arr[CFG_W'(pos - POS_W'(2))];
        end
    end
endmodule

// File: rtl/lane_start_seq.sv
module lane_start_seq
    import lane_seq_pkg::*;
#(
    parameter int FRAMES_PER_MF    = 16,
    parameter int OCTETS_PER_FRAME = 2,
    parameter int ILA_MF           = 4,
    parameter int CFG_OCTETS       = 14,
    parameter int SYNC_STAGES      = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    sync_req_n,
    input  logic                    mf_strobe,
    input  logic [7:0]              data_in,
    input  logic [CFG_OCTETS*8-1:0] cfg_in,
    output logic [7:0]              tx_octet,
    output logic                    tx_is_k,
    output logic [1:0]              link_phase
);
    localparam int MF_OCTETS  = FRAMES_PER_MF * OCTETS_PER_FRAME;
    localparam int ILA_OCTETS = MF_OCTETS * ILA_MF;
    localparam int IDX_W      = $clog2(ILA_OCTETS);

    typedef struct packed {
        phase_e           ph;
        logic [IDX_W-1:0] idx;
        logic [7:0]       oct;
        logic             k;
    } seq_t;

    seq_t             seq_d, seq_q;
    logic             sync_ok;
    logic [IDX_W-1:0] map_idx;
    logic [7:0]       map_oct;
    logic             map_k;

    seq_bit_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (sync_req_n),
        .q     (sync_ok)
    );

    ila_octet_map #(
        .MF_OCTETS  (MF_OCTETS),
        .ILA_MF     (ILA_MF),
        .CFG_OCTETS (CFG_OCTETS),
        .IDX_W      (IDX_W)
    ) u_map (
        .idx     (map_idx),
        .cfg_in  (cfg_in),
        .data_in (data_in),
        .octet   (map_oct),
        .is_k    (map_k)
    );

    // Index of the alignment octet about to be produced
    assign map_idx = (seq_q.ph == PH_ILA) ? seq_q.idx + IDX_W'(1) : '0;

    always_comb begin
        seq_d = seq_q;
        if (!sync_ok) begin
            seq_d.ph  = PH_CGS;
            seq_d.idx = '0;
            seq_d.oct = SYM_COMMA;
            seq_d.k   = 1'b1;
        end else begin
            case (seq_q.ph)
                PH_CGS: begin
                    if (mf_strobe) begin
                        seq_d.ph  = PH_ILA;
                        seq_d.idx = '0;
                        seq_d.oct = map_oct;
                        seq_d.k   = map_k;
                    end else begin
                        seq_d.oct = SYM_COMMA;
                        seq_d.k   = 1'b1;
                    end
                end
                PH_ILA: begin
                    if (seq_q.idx == IDX_W'(ILA_OCTETS - 1)) begin
                        seq_d.ph  = PH_DATA;
                        seq_d.oct = data_in;
                        seq_d.k   = 1'b0;
                    end else begin
                        seq_d.idx = map_idx;
                        seq_d.oct = map_oct;
                        seq_d.k   = map_k;
                    end
                end
                PH_DATA: begin
                    seq_d.oct = data_in;
                    seq_d.k   = 1'b0;
                end
                default: begin
                    seq_d.ph  = PH_CGS;
                    seq_d.idx = '0;
                    seq_d.oct = SYM_COMMA;
                    seq_d.k   = 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q.ph  <= PH_CGS;
            seq_q.idx <= '0;
            seq_q.oct <= SYM_COMMA;
            seq_q.k   <= 1'b1;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign tx_octet   = seq_q.oct;
    assign tx_is_k    = seq_q.k;
    assign link_phase = seq_q.ph;

    // R2: a synchronised request forces comma transmission
    p_comma_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !sync_ok |=> (tx_octet == SYM_COMMA && tx_is_k && link_phase == PH_CGS));

    // R4: a boundary strobe with the request released opens the alignment sequence
    p_ila_begin_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (link_phase == PH_CGS && sync_ok && mf_strobe)
        |=> (tx_octet == SYM_MF_START && tx_is_k && link_phase == PH_ILA));

    // R4: without a strobe the lane stays in comma transmission
    p_cgs_wait_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (link_phase == PH_CGS && !mf_strobe) |=> link_phase == PH_CGS);

    // R5: the sequence only hands over to data right after an end-of-multiframe marker
    p_ila_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (link_phase == PH_DATA && $past(link_phase) == PH_ILA)
        |-> ($past(tx_octet) == SYM_MF_END && $past(tx_is_k)));

    // R9: data phase passes the input octet through with one register of latency
    p_data_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (link_phase == PH_DATA && sync_ok)
        |=> (link_phase == PH_DATA && !tx_is_k && tx_octet == $past(data_in)));

    // R10: the control flag only accompanies control character values
    p_kflag_codes_r10: assert property (@(posedge clk) disable iff (!rst_n)
        tx_is_k |-> (tx_octet == SYM_COMMA || tx_octet == SYM_MF_START ||
                     tx_octet == SYM_MF_END || tx_octet == SYM_CFG_MARK));
endmodule

// File: tb/tb_lane_start_seq.sv
`timescale 1ns/1ps
module tb_lane_start_seq;
    localparam int CFG_OCTETS = 14;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    sync_req_n = 1'b0;
    logic                    mf_strobe = 1'b0;
    logic [7:0]              data_in = 8'h00;
    logic [CFG_OCTETS*8-1:0] cfg_in;
    logic [7:0]              tx_octet;
    logic                    tx_is_k;
    logic [1:0]              link_phase;

    int  cyc = 0;
    int  n_checks = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    typedef struct {
        int         cyc;
        logic [7:0] oct;
        logic       k;
        logic [1:0] ph;
        string      tag;
    } exp_t;

    exp_t sb_q[$];
    exp_t mon_e;

    lane_start_seq dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .sync_req_n (sync_req_n),
        .mf_strobe  (mf_strobe),
        .data_in    (data_in),
        .cfg_in     (cfg_in),
        .tx_octet   (tx_octet),
        .tx_is_k    (tx_is_k),
        .link_phase (link_phase)
    );

    always #2 clk = ~clk; // 250 MHz

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [7:0] cfg_byte(input int n);
        return 8'(8'hA0 + n);
    endfunction

    function automatic logic [7:0] pat(input int i);
        return 8'(i * 13 + 5);
    endfunction

    // Expected alignment octet, from R6, R7 and R8
    function automatic void ila_ref(input int i, input logic [7:0] d,
                                    output logic [7:0] o, output logic k,
                                    output string tag);
        int p;
        int m;
        p = i % 32;
        m = i / 32;
        if (p == 0) begin
            o = 8'h1C; k = 1'b1; tag = "R6/R10";
        end else if (p == 31) begin
            o = 8'h7C; k = 1'b1; tag = "R6/R10";
        end else if (m == 1 && p == 1) begin
            o = 8'h9C; k = 1'b1; tag = "R7/R10";
        end else if (m == 1 && p >= 2 && p <= 15) begin
            o = cfg_byte(p - 2); k = 1'b0; tag = "R7";
        end else begin
            o = d; k = 1'b0; tag = "R8";
        end
        if (i == 127) tag = {tag, "/R5"};
    endfunction

    // Driver: sets inputs for the next edge and queues the octet that edge must produce
    task automatic drive(input logic s, input logic st, input logic [7:0] d,
                         input logic [7:0] eo, input logic ek, input logic [1:0] ep,
                         input string tag);
        exp_t e;
        @(posedge clk);
        #1;
        sync_req_n = s;
        mf_strobe  = st;
        data_in    = d;
        e.cyc = cyc + 1;
        e.oct = eo;
        e.k   = ek;
        e.ph  = ep;
        e.tag = tag;
        sb_q.push_back(e);
    endtask

    task automatic expect_now(input string tag);
        exp_t e;
        @(posedge clk);
        #1;
        e.cyc = cyc;
        e.oct = 8'hBC;
        e.k   = 1'b1;
        e.ph  = 2'd0;
        e.tag = tag;
        sb_q.push_back(e);
    endtask

    task automatic ila_octets(input int first, input int last, input logic s, input int stray);
        for (int i = first; i <= last; i++) begin
            logic [7:0] o;
            logic       k;
            string      tag;
            ila_ref(i, pat(i), o, k, tag);
            if (i == stray) tag = {tag, "/R11"};
            drive(s, (i % 32 == 0) || (i == stray), pat(i), o, k, 2'd1, tag);
        end
    endtask

    // Monitor: compares queued expectations away from the active edge
    always @(negedge clk) begin
        while (sb_q.size() > 0 && sb_q[0].cyc <= cyc) begin
            mon_e = sb_q.pop_front();
            n_checks++;
            if (tx_octet !== mon_e.oct || tx_is_k !== mon_e.k || link_phase !== mon_e.ph) begin
                n_fail++;
                $display("FAIL %s cyc %0d: got oct=%h k=%b ph=%0d expected oct=%h k=%b ph=%0d",
                         mon_e.tag, cyc, tx_octet, tx_is_k, link_phase,
                         mon_e.oct, mon_e.k, mon_e.ph);
            end
        end
    end

    initial begin
        for (int n = 0; n < CFG_OCTETS; n++) cfg_in[n*8 +: 8] = cfg_byte(n);

        // R1: reset state
        expect_now("R1");
        expect_now("R1");
        @(posedge clk);
        #1 rst_n = 1'b1;

        // R2: request held low, strobes ignored
        for (int j = 0; j < 10; j++)
            drive(1'b0, (j % 3 == 0), pat(j), 8'hBC, 1'b1, 2'd0, "R1/R2");

        // R4: release; strobe before the synchroniser settles is ignored
        drive(1'b1, 1'b0, 8'h11, 8'hBC, 1'b1, 2'd0, "R4");
        drive(1'b1, 1'b1, 8'h12, 8'hBC, 1'b1, 2'd0, "R4");
        for (int j = 0; j < 3; j++)
            drive(1'b1, 1'b0, 8'h13, 8'hBC, 1'b1, 2'd0, "R4");
        // full alignment sequence, stray strobe at octet 45
        ila_octets(0, 127, 1'b1, 45);

        // R9: data right after, stray strobe R11
        for (int j = 0; j < 20; j++) begin
            string tag;
            tag = (j == 0) ? "R5/R9" : ((j == 7) ? "R9/R11" : "R9");
            drive(1'b1, (j == 0) || (j == 7), pat(200 + j), pat(200 + j), 1'b0, 2'd2, tag);
        end

        // R3: request during data, two more data octets then comma
        drive(1'b0, 1'b0, 8'h55, 8'h55, 1'b0, 2'd2, "R3");
        drive(1'b0, 1'b0, 8'h66, 8'h66, 1'b0, 2'd2, "R3");
        drive(1'b0, 1'b0, 8'h77, 8'hBC, 1'b1, 2'd0, "R3");
        for (int j = 0; j < 3; j++)
            drive(1'b0, 1'b1, 8'h78, 8'hBC, 1'b1, 2'd0, "R2");

        // Round 2: strobe on the first edge the release is visible
        drive(1'b1, 1'b0, 8'h21, 8'hBC, 1'b1, 2'd0, "R4");
        drive(1'b1, 1'b1, 8'h22, 8'hBC, 1'b1, 2'd0, "R4");
        ila_octets(0, 41, 1'b1, -1);
        // R3: request inside the configuration octets
        ila_octets(42, 43, 1'b0, -1);
        drive(1'b0, 1'b0, 8'h31, 8'hBC, 1'b1, 2'd0, "R3");
        drive(1'b0, 1'b1, 8'h32, 8'hBC, 1'b1, 2'd0, "R3");
        drive(1'b0, 1'b0, 8'h33, 8'hBC, 1'b1, 2'd0, "R3");

        repeat (3) @(posedge clk);
        @(negedge clk);
        if (sb_q.size() != 0) begin
            n_checks++;
            n_fail++;
            $display("FAIL scoreboard: %0d expected items left, expected 0", sb_q.size());
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule